// File: doc/BRIEF.md
# Warp Barrier Synchronization Unit

This unit holds warps of one core at named rendezvous points. A barrier command gives a warp index, a barrier index and a participant count. The unit parks the warp by setting its bit in a stall mask. The warp scheduler reads that mask and skips parked warps. When the warp that completes the required count arrives, every warp parked on that barrier is freed in one cycle. The completing warp is never parked, and the barrier entry returns to empty so that it can be used again.

Each barrier index has its own slot. A slot is a two-state machine with the states `SLOT_IDLE` and `SLOT_GATHER`, a mask of parked warps and an arrival counter. The slot has three transitions:
- IDLE to GATHER on a first arrival whose count is above one.
- GATHER to GATHER on a non-final arrival.
- GATHER to IDLE on the final arrival.

An arrival in IDLE whose count is one or less releases at once, and the slot stays in IDLE. If a warp arrives a second time at a barrier where it is already parked, the arrival is dropped and the unit raises a one-cycle error pulse.

Top module: `warp_barrier`

## Requirements
- R1: After reset, `stall_mask` is zero, and `rel_valid` and `dup_err` are low.
- R2: When an arrival does not complete its barrier, bit `cmd_warp` of `stall_mask` (bit i is warp i) is set in the cycle after the command.
- R3: A completing arrival does the following in the cycle after the command:
  - clears the `stall_mask` bits of all warps parked on that barrier;
  - leaves the arriving warp unstalled;
  - drives `rel_valid` high for exactly one cycle, with `rel_bar` equal to the barrier index.
- R4: An arrival with a count of 1 or 0 at an empty barrier releases at once, and no warp becomes stalled.
- R5: Arrivals at one barrier index neither add to the count of another index nor release it.
- R6: An arrival by a warp that is already parked on the same barrier is ignored: `stall_mask` is unchanged and the arrival count does not grow. `dup_err` is high for one cycle after the command.
- R7: After a release, the barrier is empty. A later arrival at the same index starts a new round that needs the full count again.
- R8: Each arrival compares the number of arrivals so far, including itself, against the count carried by that same command.
- R9: `stall_mask` changes only in the cycle after an accepted command. With `cmd_valid` low, `stall_mask` holds its value and `rel_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Barrier command present this cycle |
| cmd_warp | input | $clog2(NUM_WARPS) | Index of the arriving warp |
| cmd_bar | input | $clog2(NUM_BARS) | Barrier index |
| cmd_count | input | $clog2(NUM_WARPS+1) | Number of participants required |
| stall_mask | output | NUM_WARPS | Parked warps, with bit i for warp i |
| rel_valid | output | 1 | One-cycle pulse when a barrier releases |
| rel_bar | output | $clog2(NUM_BARS) | Index of the barrier that released |
| dup_err | output | 1 | One-cycle pulse on a duplicate arrival |

## Verification
The bench goes after the completing arrival, the duplicate arrival, count-of-one release, interleaved barriers, reuse after release, and a count that changes between arrivals.

A design that parks the final warp would leave one stalled warp after each release. A design that counts a duplicate would release one arrival early. A design that does not clear its counter would free the next round too soon. A design that shares state between indices would free the wrong barrier or report the wrong `rel_bar`.

// File: rtl/warp_barrier_pkg.sv
package warp_barrier_pkg;
    typedef enum logic {
        SLOT_IDLE   = 1'b0,
        SLOT_GATHER = 1'b1
    } slot_state_e;
endpackage

// File: rtl/warp_barrier_slot.sv
module warp_barrier_slot
    import warp_barrier_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int CNT_W     = $clog2(NUM_WARPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [NUM_WARPS-1:0] warp_oh,
    input  logic [CNT_W-1:0]     need,
    output logic [NUM_WARPS-1:0] park_mask,
    output logic                 rel,
    output logic                 dup
);
    slot_state_e          state_q, state_d;
    logic [NUM_WARPS-1:0] mask_q, mask_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic                 dup_c, arrive, fin;
    logic [CNT_W:0]       seen;

    assign dup_c  = hit && |(mask_q & warp_oh);
    assign arrive = hit && !dup_c;
    assign seen   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign fin    = arrive && (seen >= {1'b0, need});

    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (arrive && !fin) begin
                    state_d = SLOT_GATHER;
                    mask_d  = warp_oh;
                    cnt_d   = CNT_W'(1);
                end
            end
            SLOT_GATHER: begin
                if (fin) begin
                    state_d = SLOT_IDLE;
                    mask_d  = '0;
                    cnt_d   = '0;
                end else if (arrive) begin
                    mask_d = mask_q | warp_oh;
                    cnt_d  = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            mask_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            cnt_q   <= cnt_d;
        end
    end

    // output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel <= 1'b0;
            dup <= 1'b0;
        end else begin
            rel <= fin;
            dup <= dup_c;
        end
    end

    assign park_mask = mask_q;
endmodule

// File: rtl/warp_barrier_collect.sv
module warp_barrier_collect #(
    parameter int NUM_WARPS = 4,
    parameter int NUM_BARS  = 4,
    parameter int BID_W     = $clog2(NUM_BARS)
) (
    input  logic [NUM_WARPS-1:0] masks [NUM_BARS],
    input  logic [NUM_BARS-1:0]  rel_vec,
    input  logic [NUM_BARS-1:0]  dup_vec,
    output logic [NUM_WARPS-1:0] stall_mask,
    output logic                 rel_valid,
    output logic [BID_W-1:0]     rel_bar,
    output logic                 dup_err
);
    always_comb begin
        stall_mask = '0;
        rel_bar    = '0;
        for (int b = 0; b < NUM_BARS; b++) begin
            stall_mask = stall_mask | masks[b];
            if (rel_vec[b]) rel_bar = BID_W'(b);
        end
    end

    assign rel_valid = |rel_vec;
    assign dup_err   = |dup_vec;
endmodule

// File: rtl/warp_barrier.sv
module warp_barrier #(
    parameter int NUM_WARPS = 4,
    parameter int NUM_BARS  = 4,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int BID_W    = $clog2(NUM_BARS),
    localparam int CNT_W    = $clog2(NUM_WARPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [WID_W-1:0]     cmd_warp,
    input  logic [BID_W-1:0]     cmd_bar,
    input  logic [CNT_W-1:0]     cmd_count,
    output logic [NUM_WARPS-1:0] stall_mask,
    output logic                 rel_valid,
    output logic [BID_W-1:0]     rel_bar,
    output logic                 dup_err
);
    logic [NUM_WARPS-1:0] warp_oh;
    logic [NUM_WARPS-1:0] masks [NUM_BARS];
    logic [NUM_BARS-1:0]  rel_vec, dup_vec;

    assign warp_oh = NUM_WARPS'(1) << cmd_warp;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
        warp_barrier_slot #(
            .NUM_WARPS(NUM_WARPS),
            .CNT_W    (CNT_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (cmd_valid && (cmd_bar == BID_W'(g))),
            .warp_oh  (warp_oh),
            .need     (cmd_count),
            .park_mask(masks[g]),
            .rel      (rel_vec[g]),
            .dup      (dup_vec[g])
        );
    end

    warp_barrier_collect #(
        .NUM_WARPS(NUM_WARPS),
        .NUM_BARS (NUM_BARS),
        .BID_W    (BID_W)
    ) u_collect (
        .masks     (masks),
        .rel_vec   (rel_vec),
        .dup_vec   (dup_vec),
        .stall_mask(stall_mask),
        .rel_valid (rel_valid),
        .rel_bar   (rel_bar),
        .dup_err   (dup_err)
    );
endmodule

// File: rtl/warp_barrier_checker.sv
module warp_barrier_checker #(
    parameter int NUM_WARPS = 4,
    parameter int NUM_BARS  = 4,
    parameter int WID_W     = $clog2(NUM_WARPS),
    parameter int BID_W     = $clog2(NUM_BARS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [WID_W-1:0]     cmd_warp,
    input logic [NUM_WARPS-1:0] stall_mask,
    input logic                 rel_valid,
    input logic                 dup_err
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (stall_mask == '0 && !rel_valid && !dup_err)); // R1
    AST_ARRIVE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (stall_mask[$past(cmd_warp)] || rel_valid || dup_err)); // R2
    AST_REL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> $past(cmd_valid)); // R3
    AST_DUP_HOLDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err |-> ($stable(stall_mask) && !rel_valid)); // R6
    AST_DUP_WAS_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err |-> ($past(cmd_valid) && $past(stall_mask[cmd_warp]))); // R6
    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_valid) |-> ($stable(stall_mask) && !rel_valid)); // R9
endmodule

bind warp_barrier warp_barrier_checker #(
    .NUM_WARPS(NUM_WARPS),
    .NUM_BARS (NUM_BARS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_warp  (cmd_warp),
    .stall_mask(stall_mask),
    .rel_valid (rel_valid),
    .dup_err   (dup_err)
);

// File: tb/warp_barrier_bench.sv
module warp_barrier_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_warp = '0;
    logic [1:0] cmd_bar = '0;
    logic [2:0] cmd_count = '0;
    logic [3:0] stall_mask;
    logic       rel_valid;
    logic [1:0] rel_bar;
    logic       dup_err;
    int         n_tests = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    warp_barrier u_warp_barrier (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_warp(cmd_warp),
        .cmd_bar(cmd_bar), .cmd_count(cmd_count), .stall_mask(stall_mask),
        .rel_valid(rel_valid), .rel_bar(rel_bar), .dup_err(dup_err)
    );

    task automatic check(input string req, input logic [3:0] m, input logic r,
                         input logic [1:0] b, input logic e);
        n_tests++;
        if (stall_mask !== m || rel_valid !== r || dup_err !== e || (r && rel_bar !== b)) begin
            n_fail++;
            $display("FAIL %s: mask=%b rel=%b bar=%0d err=%b expected mask=%b rel=%b bar=%0d err=%b",
                     req, stall_mask, rel_valid, rel_bar, dup_err, m, r, b, e);
        end
    endtask

    // one command, outputs sampled at the following falling edge
    task automatic arrive(input int w, input int b, input int n);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_warp  = 2'(w);
        cmd_bar   = 2'(b);
        cmd_count = 3'(n);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset", 4'b0000, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_basic;
        arrive(0, 0, 3); check("R2 first park", 4'b0001, 1'b0, 2'd0, 1'b0);
        arrive(1, 0, 3); check("R2 second park", 4'b0011, 1'b0, 2'd0, 1'b0);
        arrive(2, 0, 3); check("R3 final release", 4'b0000, 1'b1, 2'd0, 1'b0);
        @(negedge clk);  check("R3 pulse one cycle", 4'b0000, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_single;
        arrive(3, 2, 1); check("R4 count one", 4'b0000, 1'b1, 2'd2, 1'b0);
        arrive(1, 1, 0); check("R4 count zero", 4'b0000, 1'b1, 2'd1, 1'b0);
    endtask

    task automatic t_indep;
        arrive(0, 1, 2); check("R5 park bar1", 4'b0001, 1'b0, 2'd0, 1'b0);
        arrive(1, 2, 2); check("R5 park bar2 no cross", 4'b0011, 1'b0, 2'd0, 1'b0);
        arrive(2, 1, 2); check("R5 release bar1 only", 4'b0010, 1'b1, 2'd1, 1'b0);
        arrive(3, 2, 2); check("R5 release bar2", 4'b0000, 1'b1, 2'd2, 1'b0);
    endtask

    task automatic t_dup;
        arrive(0, 3, 3); check("R6 park", 4'b0001, 1'b0, 2'd0, 1'b0);
        arrive(0, 3, 3); check("R6 duplicate flagged", 4'b0001, 1'b0, 2'd0, 1'b1);
        arrive(1, 3, 3); check("R6 duplicate not counted", 4'b0011, 1'b0, 2'd0, 1'b0);
        arrive(2, 3, 3); check("R6 release after third", 4'b0000, 1'b1, 2'd3, 1'b0);
    endtask

    task automatic t_reuse;
        arrive(0, 0, 2); check("R7 round one park", 4'b0001, 1'b0, 2'd0, 1'b0);
        arrive(1, 0, 2); check("R7 round one release", 4'b0000, 1'b1, 2'd0, 1'b0);
        arrive(2, 0, 2); check("R7 round two needs full count", 4'b0100, 1'b0, 2'd0, 1'b0);
        arrive(3, 0, 2); check("R7 round two release", 4'b0000, 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_count;
        arrive(0, 1, 4); check("R8 park with count four", 4'b0001, 1'b0, 2'd0, 1'b0);
        arrive(1, 1, 2); check("R8 own count used", 4'b0000, 1'b1, 2'd1, 1'b0);
    endtask

    task automatic t_all;
        arrive(0, 3, 4); check("R2 all one", 4'b0001, 1'b0, 2'd0, 1'b0);
        arrive(1, 3, 4); check("R2 all two", 4'b0011, 1'b0, 2'd0, 1'b0);
        arrive(2, 3, 4); check("R2 all three", 4'b0111, 1'b0, 2'd0, 1'b0);
        arrive(3, 3, 4); check("R3 all warps freed", 4'b0000, 1'b1, 2'd3, 1'b0);
    endtask

    task automatic t_quiet;
        arrive(0, 2, 3); check("R9 park", 4'b0001, 1'b0, 2'd0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); check("R9 idle stable", 4'b0001, 1'b0, 2'd0, 1'b0);
        end
        arrive(1, 2, 2); check("R9 cleanup release", 4'b0000, 1'b1, 2'd2, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_single();
        t_indep();
        t_dup();
        t_reuse();
        t_count();
        t_all();
        t_quiet();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule